// File: doc/BRIEF.md
# Integer-to-Float Converter with Dynamic Rounding

This unit turns a 64-bit integer register value into an IEEE 754 binary64 value for the floating-point register file. A two-bit type code picks one of four readings of the source: signed or unsigned, 32 or 64 bits wide. A 32-bit reading uses only the low word. A select input chooses the destination precision. In double precision the value is rounded straight to binary64. In single precision it is first rounded to binary32 and then re-expressed in the 64-bit register layout, with a rebiased exponent and the fraction padded with zeros.

Rounding follows the dynamic rounding mode given at the input. There is one exception. A 32-bit integer always fits in a double, so that case is exact: it raises no inexact flag and does not request a status-flag update. Every other case rounds, reports whether any bits were dropped, and asks the surrounding status logic to commit its flags.

Along with the value, the unit returns the 5-bit result-class code and a condition-field nibble for the record form of the operation. The nibble is built from the caller's summary bits after this operation's inexact report is merged in. Each result appears one clock after the request is presented.

Top module: `i2fConvert`

## Requirements
- R1: `intType` selects the source reading: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. The 32-bit readings use `srcWord[31:0]` and ignore `srcWord[63:32]`. An unsigned reading never gives a negative result.
- R2: When `intType` is 0 or 1 and `singleSel` is 0, the result is the exact binary64 value of the integer, `inexact` is 0 and `flagWrEn` is 0.
- R3: For every other combination, the result is rounded by `roundMode`: 00 = to nearest, ties to even; 01 = toward zero; 10 = toward +infinity; 11 = toward -infinity. `flagWrEn` is 1, and `inexact` is 1 exactly when nonzero bits were dropped.
- R4: With `singleSel` = 1, the value is rounded to a 24-bit significand. It is returned in binary64 layout (sign in bit 63, exponent in bits 62:52 with bias 1023, fraction in bits 51:0), and fraction bits 28:0 are zero.
- R5: A zero source gives +0.0 (all 64 bits zero) with class code 00010.
- R6: A negative signed source gives a result with bit 63 set and class code 01000. A positive nonzero source gives class code 00100.
- R7: A request with `inValid` = 1 at a rising edge appears on the outputs after that edge, with `outValid` = 1, for one cycle.
- R8: When `rcBit` = 1, `crWrEn` pulses together with `outValid`. `crNibble` is `{statusIn[3] | (inexact of this operation), statusIn[2:0]}`, where `statusIn` carries the summary bits {FX, FEX, VX, OX} from bit 3 down to bit 0.
- R9: While `rstN` is low, `outValid`, `flagWrEn`, `crWrEn` and `inexact` are 0, and `resBits` and `resClass` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| srcWord | input | 64 | Integer source register |
| intType | input | 2 | Integer type code |
| singleSel | input | 1 | 1 = round to single precision |
| roundMode | input | 2 | Dynamic rounding mode |
| rcBit | input | 1 | Record form: request condition-field update |
| statusIn | input | 4 | Current FX, FEX, VX, OX summary bits |
| outValid | output | 1 | Result valid |
| resBits | output | 64 | Floating-point result in binary64 layout |
| inexact | output | 1 | Bits were lost in rounding |
| resClass | output | 5 | Result-class code |
| flagWrEn | output | 1 | Status flags are to be committed |
| crWrEn | output | 1 | Condition field is to be written |
| crNibble | output | 4 | Condition-field value |

## Verification
The assertions assume the request inputs are stable and meaningful in any cycle where `inValid` is high. They also assume `rstN` is released synchronously and that no request arrives during reset. The bench drives all inputs on the falling edge and raises `inValid` only after reset is released, so these conditions always hold. Because every two-bit code is legal, the random stimulus covers the full input space without any masking. Directed values target the rounding boundaries: 2^53+1, 2^24+1, the all-ones 64-bit value, the most negative 64-bit value, and low words with garbage in the upper half.

// File: rtl/i2fPkg.sv
package i2fPkg;
  localparam int WORD_W     = 64;
  localparam int HALF_W     = WORD_W / 2;
  localparam int DBL_MANT_W = 52;
  localparam int SGL_MANT_W = 23;
  localparam int PAD_W      = DBL_MANT_W - SGL_MANT_W;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_BIAS   = 1023;
  localparam int LZ_W       = $clog2(WORD_W);
  localparam int CLASS_W    = 5;
  localparam int STAT_W     = 4;

  localparam logic [CLASS_W-1:0] CLS_POS_ZERO = 5'b00010;
  localparam logic [CLASS_W-1:0] CLS_POS_NORM = 5'b00100;
  localparam logic [CLASS_W-1:0] CLS_NEG_NORM = 5'b01000;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } roundMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       wideSrc;
    logic       signedSrc;
    logic       toSingle;
    roundMode_e rm;
  } cvtStrobe_t;

  // count of zero bits above the most significant one
  function automatic logic [LZ_W-1:0] leadZeros(input logic [WORD_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            seen;
    n    = '0;
    seen = 1'b0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      else if (!seen) n = n + LZ_W'(1);
    end
    return n;
  endfunction
endpackage

// File: rtl/i2fRound.sv
module i2fRound
  import i2fPkg::*;
#(
  parameter int MANT_W = 52
) (
  input  logic [WORD_W-1:0] normed,
  input  logic              negIn,
  input  roundMode_e        rm,
  output logic [MANT_W-1:0] mant,
  output logic              carry,
  output logic              lost
);
  localparam int GUARD_POS = WORD_W - 2 - MANT_W;

  logic [MANT_W-1:0] kept;
  logic              guardBit;
  logic              stickyBit;
  logic              roundUp;

  // hidden bit sits at WORD_W-1; fraction directly below it
  assign kept      = normed[WORD_W-2 -: MANT_W];
  assign guardBit  = normed[GUARD_POS];
  assign stickyBit = |normed[GUARD_POS-1:0];
  assign lost      = guardBit | stickyBit;

  always_comb begin
    unique case (rm)
      RM_NEAR: roundUp = guardBit & (stickyBit | kept[0]);
      RM_ZERO: roundUp = 1'b0;
      RM_UP:   roundUp = lost & ~negIn;
      RM_DOWN: roundUp = lost & negIn;
      default: roundUp = 1'b0;
    endcase
  end

  // an all-ones fraction wraps to zero and bumps the exponent
  assign {carry, mant} = {1'b0, kept} + (MANT_W + 1)'(roundUp);
endmodule

// File: rtl/i2fDatapath.sv
module i2fDatapath
  import i2fPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  srcWord,
  input  cvtStrobe_t         strobe,
  output logic               lostBits,
  output logic [WORD_W-1:0]  resBits,
  output logic [CLASS_W-1:0] resClass
);
  logic [WORD_W-1:0]     operand;
  logic [WORD_W-1:0]     magnitude;
  logic [WORD_W-1:0]     normed;
  logic                  negIn;
  logic                  isZero;
  logic [LZ_W-1:0]       lz;
  logic [DBL_MANT_W-1:0] dMant;
  logic                  dCarry;
  logic                  dLost;
  logic [SGL_MANT_W-1:0] sMant;
  logic                  sCarry;
  logic                  sLost;
  logic                  bump;
  logic [DBL_EXP_W-1:0]  expField;
  logic [DBL_MANT_W-1:0] fracField;
  logic [WORD_W-1:0]     packWord;
  logic [CLASS_W-1:0]    classNext;

  always_comb begin
    if (strobe.wideSrc)        operand = srcWord;
    else if (strobe.signedSrc) operand = {{HALF_W{srcWord[HALF_W-1]}}, srcWord[HALF_W-1:0]};
    else                       operand = {{HALF_W{1'b0}}, srcWord[HALF_W-1:0]};
  end

  assign negIn     = strobe.signedSrc & operand[WORD_W-1];
  assign magnitude = negIn ? (~operand + WORD_W'(1)) : operand;
  assign isZero    = (magnitude == '0);
  assign lz        = leadZeros(magnitude);
  assign normed    = magnitude << lz;

  i2fRound #(.MANT_W(DBL_MANT_W)) uRndDbl (
    .normed(normed), .negIn(negIn), .rm(strobe.rm),
    .mant(dMant), .carry(dCarry), .lost(dLost)
  );

  i2fRound #(.MANT_W(SGL_MANT_W)) uRndSgl (
    .normed(normed), .negIn(negIn), .rm(strobe.rm),
    .mant(sMant), .carry(sCarry), .lost(sLost)
  );

  always_comb begin
    bump      = strobe.toSingle ? sCarry : dCarry;
    fracField = strobe.toSingle ? {sMant, {PAD_W{1'b0}}} : dMant;
    expField  = DBL_EXP_W'(DBL_BIAS + WORD_W - 1) - DBL_EXP_W'(lz) + DBL_EXP_W'(bump);
    packWord  = isZero ? '0 : {negIn, expField, fracField};
    if (isZero)     classNext = CLS_POS_ZERO;
    else if (negIn) classNext = CLS_NEG_NORM;
    else            classNext = CLS_POS_NORM;
  end

  assign lostBits = strobe.toSingle ? sLost : dLost;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resBits  <= '0;
      resClass <= '0;
    end else if (strobe.load) begin
      resBits  <= packWord;
      resClass <= classNext;
    end
  end

  p_unsigned_pos_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.signedSrc) |=> !resBits[WORD_W-1]);

  p_single_tail_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.toSingle) |=> (resBits[PAD_W-1:0] == '0));

  p_zero_class_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && srcWord == '0) |=> (resBits == '0 && resClass == CLS_POS_ZERO));

  p_neg_class_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.signedSrc && strobe.wideSrc && srcWord[WORD_W-1])
      |=> (resBits[WORD_W-1] && resClass == CLS_NEG_NORM));
endmodule

// File: rtl/i2fControl.sv
module i2fControl
  import i2fPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        intType,
  input  logic              singleSel,
  input  logic [1:0]        roundMode,
  input  logic              rcBit,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              lostBits,
  output cvtStrobe_t        strobe,
  output logic              outValid,
  output logic              inexact,
  output logic              flagWrEn,
  output logic              crWrEn,
  output logic [STAT_W-1:0] crNibble
);
  logic exactPath;
  logic rawInexact;

  always_comb begin
    strobe.load      = inValid;
    strobe.wideSrc   = intType[1];
    strobe.signedSrc = ~intType[0];
    strobe.toSingle  = singleSel;
    strobe.rm        = roundMode_e'(roundMode);
  end

  // a 32-bit integer always fits a binary64 significand
  assign exactPath  = ~intType[1] & ~singleSel;
  assign rawInexact = lostBits & ~exactPath;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      inexact  <= 1'b0;
      flagWrEn <= 1'b0;
      crWrEn   <= 1'b0;
      crNibble <= '0;
    end else begin
      outValid <= inValid;
      inexact  <= inValid & rawInexact;
      flagWrEn <= inValid & ~exactPath;
      crWrEn   <= inValid & rcBit;
      if (inValid)
        crNibble <= {statusIn[STAT_W-1] | rawInexact, statusIn[STAT_W-2:0]};
    end
  end

  p_exact_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !intType[1] && !singleSel) |=> (!flagWrEn && !inexact));

  p_flag_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (intType[1] || singleSel)) |=> flagWrEn);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_cr_copy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rcBit) |=> (crWrEn && crNibble[STAT_W-2:0] == $past(statusIn[STAT_W-2:0])));
endmodule

// File: rtl/i2fConvert.sv
module i2fConvert
  import i2fPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [WORD_W-1:0]  srcWord,
  input  logic [1:0]         intType,
  input  logic               singleSel,
  input  logic [1:0]         roundMode,
  input  logic               rcBit,
  input  logic [STAT_W-1:0]  statusIn,
  output logic               outValid,
  output logic [WORD_W-1:0]  resBits,
  output logic               inexact,
  output logic [CLASS_W-1:0] resClass,
  output logic               flagWrEn,
  output logic               crWrEn,
  output logic [STAT_W-1:0]  crNibble
);
  cvtStrobe_t strobe;
  logic       lostBits;

  i2fControl uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .intType(intType),
    .singleSel(singleSel), .roundMode(roundMode), .rcBit(rcBit),
    .statusIn(statusIn), .lostBits(lostBits), .strobe(strobe),
    .outValid(outValid), .inexact(inexact), .flagWrEn(flagWrEn),
    .crWrEn(crWrEn), .crNibble(crNibble)
  );

  i2fDatapath uDp (
    .clk(clk), .rstN(rstN), .srcWord(srcWord), .strobe(strobe),
    .lostBits(lostBits), .resBits(resBits), .resClass(resClass)
  );

  p_cr_with_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    crWrEn |-> outValid);
endmodule

// File: tb/i2fConvert_test.sv
module i2fConvert_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] srcWord = '0;
  logic [1:0]  intType = '0;
  logic        singleSel = 1'b0;
  logic [1:0]  roundMode = '0;
  logic        rcBit = 1'b0;
  logic [3:0]  statusIn = '0;
  logic        outValid, inexact, flagWrEn, crWrEn;
  logic [63:0] resBits;
  logic [4:0]  resClass;
  logic [3:0]  crNibble;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2fConvert uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcWord(srcWord),
    .intType(intType), .singleSel(singleSel), .roundMode(roundMode),
    .rcBit(rcBit), .statusIn(statusIn), .outValid(outValid),
    .resBits(resBits), .inexact(inexact), .resClass(resClass),
    .flagWrEn(flagWrEn), .crWrEn(crWrEn), .crNibble(crNibble)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bit-level reference, built from division and remainder
  function automatic logic [63:0] refConvert(input logic [63:0] s, input logic [1:0] it,
      input logic sgl, input logic [1:0] rm, output logic lostOut, output logic [4:0] clsOut);
    logic [63:0] op, mag, q, rem, half, fracv;
    logic neg, up;
    int p, k, prec;
    case (it)
      2'd0: op = {{32{s[31]}}, s[31:0]};
      2'd1: op = {32'h0, s[31:0]};
      default: op = s;
    endcase
    neg = (it[0] == 1'b0) && op[63];
    mag = neg ? (64'd0 - op) : op;
    lostOut = 1'b0;
    if (mag == 64'd0) begin
      clsOut = 5'b00010;
      return 64'd0;
    end
    clsOut = neg ? 5'b01000 : 5'b00100;
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    prec = sgl ? 24 : 53;
    if (p < prec) begin
      q = mag << (prec - 1 - p);
    end else begin
      k = p - prec + 1;
      q = mag >> k;
      rem = mag - (q << k);
      half = 64'd1 << (k - 1);
      lostOut = (rem != 0);
      case (rm)
        2'b00: up = (rem > half) || (rem == half && q[0]);
        2'b01: up = 1'b0;
        2'b10: up = lostOut && !neg;
        default: up = lostOut && neg;
      endcase
      q = q + {63'd0, up};
      if (q == (64'd1 << prec)) begin
        q = q >> 1;
        p = p + 1;
      end
    end
    fracv = q & ((64'd1 << (prec - 1)) - 64'd1);
    if (sgl) fracv = fracv << 29;
    return {neg, 11'(p + 1023), fracv[51:0]};
  endfunction

  task automatic runOne(input string tag, input logic [63:0] s, input logic [1:0] it,
      input logic sgl, input logic [1:0] rm, input logic rc, input logic [3:0] st);
    logic [63:0] eRes;
    logic eLost, eFlag, eInex;
    logic [4:0] eCls;
    string flagTag, clsTag;
    eRes    = refConvert(s, it, sgl, rm, eLost, eCls);
    eFlag   = it[1] | sgl;
    eInex   = eFlag & eLost;
    flagTag = eFlag ? "R3" : "R2";
    clsTag  = (eCls == 5'b00010) ? "R5" : "R6";
    @(negedge clk);
    srcWord = s; intType = it; singleSel = sgl; roundMode = rm; rcBit = rc; statusIn = st;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R7", "outValid", {63'd0, outValid}, 64'd1);
    chk(tag, "result", resBits, eRes);
    chk(flagTag, "inexact", {63'd0, inexact}, {63'd0, eInex});
    chk(flagTag, "flagWrEn", {63'd0, flagWrEn}, {63'd0, eFlag});
    chk(clsTag, "class", {59'd0, resClass}, {59'd0, eCls});
    chk("R8", "crWrEn", {63'd0, crWrEn}, {63'd0, rc});
    if (rc) chk("R8", "crNibble", {60'd0, crNibble}, {60'd0, st[3] | eInex, st[2:0]});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "outValid", {63'd0, outValid}, 64'd0);
    chk("R9", "resBits", resBits, 64'd0);
    chk("R9", "flagWrEn", {63'd0, flagWrEn}, 64'd0);
    chk("R9", "crWrEn", {63'd0, crWrEn}, 64'd0);
    chk("R9", "resClass", {59'd0, resClass}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7", "idle outValid", {63'd0, outValid}, 64'd0);

    for (int m = 0; m < 4; m++) begin
      runOne("R3", 64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'(m), 1'b1, 4'b0000); // 2^53+1
      runOne("R3", 64'hFFDF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 2'(m), 1'b1, 4'b0110); // -(2^53+1)
      runOne("R4", 64'h0000_0000_0100_0001, 2'd1, 1'b1, 2'(m), 1'b1, 4'b0001); // 2^24+1
      runOne("R4", 64'hFFFF_FFFF_FEFF_FFFF, 2'd0, 1'b1, 2'(m), 1'b0, 4'b0000); // -(2^24+1)
      runOne("R3", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'(m), 1'b1, 4'b1000); // max u64
      runOne("R4", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 2'(m), 1'b0, 4'b0000);
      runOne("R3", 64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'(m), 1'b1, 4'b0000); // min s64
      runOne("R3", 64'h0000_0000_0000_0000, 2'd2, 1'b0, 2'(m), 1'b1, 4'b0000);
      runOne("R3", 64'h0030_0000_0000_0001, 2'd3, 1'b0, 2'(m), 1'b0, 4'b0000);
      runOne("R2", 64'h0000_0000_7FFF_FFFF, 2'd0, 1'b0, 2'(m), 1'b1, 4'b0101);
    end
    // R1 upper word ignored for 32-bit readings
    runOne("R1", 64'hDEAD_BEEF_FFFF_FFFF, 2'd0, 1'b0, 2'd0, 1'b1, 4'b0000);
    runOne("R1", 64'hDEAD_BEEF_FFFF_FFFF, 2'd1, 1'b0, 2'd0, 1'b1, 4'b0000);
    runOne("R1", 64'hFFFF_FFFF_8000_0000, 2'd0, 1'b0, 2'd1, 1'b0, 4'b0000);
    runOne("R1", 64'hFFFF_FFFF_8000_0000, 2'd1, 1'b0, 2'd1, 1'b0, 4'b0000);
    runOne("R5", 64'h1234_5678_0000_0000, 2'd1, 1'b1, 2'd2, 1'b1, 4'b1111);
    runOne("R5", 64'h0, 2'd0, 1'b0, 2'd3, 1'b1, 4'b0000);

    for (int n = 0; n < N_RANDOM; n++) begin
      logic [63:0] s;
      logic [1:0] it;
      logic sgl;
      s   = {$urandom, $urandom};
      s   = s >> ($urandom % 64);
      it  = 2'($urandom);
      sgl = 1'($urandom);
      runOne(sgl ? "R4" : (it[1] ? "R3" : "R2"), s, it, sgl, 2'($urandom), 1'($urandom), 4'($urandom));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule